// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects sixteen level-sensitive interrupt lines and turns them into two requests for a processor: a fast, non-vectored request and a normal, vectored request. Software sets, per input, whether it may request at all and which of the two classes it belongs to. Sixteen priority slots map inputs to vectors. Each slot has an enable, a source index that picks the input it watches, and a vector address. Slot 0 wins over every other slot, and the last slot loses to every other slot.

The processor reads the vector register to learn which handler to run. That read also acknowledges the winning slot and places it in service. While a slot is in service, that slot and every lower-priority slot are held off. A higher-priority slot can still preempt. A write to the end-of-interrupt register releases the most recently serviced slot. When no local slot is eligible, the vector read returns the vector of a second, downstream controller if that controller is requesting, and otherwise returns a programmable default vector. Two of these blocks chained this way give 32 vectored sources.

The register bus is a plain single-cycle access port with no back-pressure. A read returns data combinationally in the cycle that `bus_sel_i` is high with `bus_we_i` low. Every side effect, whether a register write, an acknowledge or a release, takes effect at the rising clock edge that ends that cycle. The bus performs one access per cycle. Interrupt inputs are assumed synchronous to `clk_i`.

Top module: `vpic_top`

## Requirements
- R1: After reset, every input is disabled, every input is in the normal class, every slot is disabled with source 0, no slot is in service, the default vector is 0, and `irq_o`, `fiq_o` and `chain_ack_o` are low.
- R2: The input enable register is at word address 0x03, with bit i for input i. An input whose enable bit is clear raises no request and shows as 0 in both masked status registers.
- R3: The class select register is at word address 0x04, with bit i for input i. A set bit puts an enabled input in the fast class. A clear bit puts it in the normal class.
- R4: `fiq_o` is high exactly when some enabled fast-class input is high. It does not depend on slots or on service state.
- R5: The control word for slot k is at word address 0x10+k. Bit 5 is the slot enable, and bits 3:0 are the source index. The vector for slot k is at word address 0x20+k. A slot is active when it is enabled and its source input is enabled, in the normal class and high. A disabled slot is never active.
- R6: A read of the vector register at word address 0x00 returns the vector of the lowest-numbered active slot that is not held off.
- R7: A vector read that returns a local slot vector puts that slot in service. If no other slot is eligible after that, `irq_o` falls in the next cycle.
- R8: While any slot is in service, the lowest-numbered in-service slot and all higher-numbered slots are held off. Lower-numbered active slots still request and win.
- R9: A write of any value to word address 0x02 releases the lowest-numbered in-service slot. A write with nothing in service has no effect.
- R10: A vector read with no eligible local slot returns `chain_vec_i` when `chain_req_i` is high, and pulses `chain_ack_o` in that cycle. Otherwise it returns the default vector held at word address 0x01. Such a read changes no service state.
- R11: Read-only status at word address 0x05 gives the raw input levels. Word address 0x06 gives the enabled fast-class levels. Word address 0x07 gives the enabled normal-class levels.
- R12: `irq_o` is high exactly when some local slot is eligible or `chain_req_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 16 | Interrupt input levels |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal vectored request |
| fiq_o | output | 1 | Fast non-vectored request |
| chain_req_i | input | 1 | Downstream controller is requesting |
| chain_vec_i | input | 32 | Downstream controller vector |
| chain_ack_o | output | 1 | Downstream vector was taken by this read |

## Verification
The bench covers four hazards. The first is nested service: a lower-numbered slot preempts while a higher-numbered one is in service. A design that held off every slot would then leave `irq_o` low and return the default vector. The second is repeated vector reads while a slot is held off. A design that acknowledged with no winner would corrupt the service state and return the wrong vectors after the release. The third is the source-index remap of a slot and a disabled slot whose source is high. These expose a design that priorities by input number rather than by slot. The last is the chain fallback and the class select. These expose `chain_ack_o` pulsing on a local win, or a fast-class input leaking into the vectored path.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_VEC  = 6'h00;
  localparam logic [AW-1:0] A_DEF  = 6'h01;
  localparam logic [AW-1:0] A_EOI  = 6'h02;
  localparam logic [AW-1:0] A_EN   = 6'h03;
  localparam logic [AW-1:0] A_FSEL = 6'h04;
  localparam logic [AW-1:0] A_RAW  = 6'h05;
  localparam logic [AW-1:0] A_FST  = 6'h06;
  localparam logic [AW-1:0] A_NST  = 6'h07;
  localparam logic [1:0] PG_CTL = 2'b01;
  localparam logic [1:0] PG_VEC = 2'b10;
  localparam int SLOT_EN_BIT = 5;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} bus_op_e;
endpackage

// File: rtl/vpic_cfg.sv
module vpic_cfg
  import vpic_pkg::*;
#(
  parameter int N  = 16,
  parameter int VW = 32,
  parameter int SW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [VW-1:0]         wdata_i,
  output logic [N-1:0]          in_en_o,
  output logic [N-1:0]          fast_sel_o,
  output logic [VW-1:0]         def_vec_o,
  output logic [N-1:0]          slot_en_o,
  output logic [N-1:0][SW-1:0]  slot_src_o,
  output logic [N-1:0][VW-1:0]  slot_vec_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      in_en_o    <= '0;
      fast_sel_o <= '0;
      def_vec_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_EN)   in_en_o    <= wdata_i[N-1:0];
      if (addr_i == A_FSEL) fast_sel_o <= wdata_i[N-1:0];
      if (addr_i == A_DEF)  def_vec_o  <= wdata_i;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam logic [3:0] KIDX = 4'(k);
    logic hit_ctl, hit_vec;
    assign hit_ctl = wr_i && (addr_i[5:4] == PG_CTL) && (addr_i[3:0] == KIDX);
    assign hit_vec = wr_i && (addr_i[5:4] == PG_VEC) && (addr_i[3:0] == KIDX);
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        slot_en_o[k]  <= 1'b0;
        slot_src_o[k] <= '0;
        slot_vec_o[k] <= '0;
      end else begin
        if (hit_ctl) begin
          slot_en_o[k]  <= wdata_i[SLOT_EN_BIT];
          slot_src_o[k] <= wdata_i[SW-1:0];
        end
        if (hit_vec) slot_vec_o[k] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int N  = 16,
  parameter int SW = 4
) (
  input  logic [N-1:0]         norm_stat_i,
  input  logic [N-1:0]         slot_en_i,
  input  logic [N-1:0][SW-1:0] slot_src_i,
  input  logic [N-1:0]         allowed_i,
  output logic [N-1:0]         grant_o,
  output logic [SW-1:0]        win_idx_o,
  output logic                 win_valid_o
);
  logic [N-1:0] active;

  for (genvar k = 0; k < N; k++) begin : g_act
    assign active[k] = slot_en_i[k] && norm_stat_i[slot_src_i[k]] && allowed_i[k];
  end

  always_comb begin
    grant_o     = '0;
    win_idx_o   = '0;
    win_valid_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (active[k]) begin
        grant_o     = '0;
        grant_o[k]  = 1'b1;
        win_idx_o   = SW'(k);
        win_valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpic_svc.sv
module vpic_svc #(
  parameter int N  = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic [SW-1:0] win_idx_i,
  input  logic          eoi_i,
  output logic [N-1:0]  allowed_o
);
  logic [N-1:0] isr_q, isr_d;

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int k = 0; k < N; k++) begin
      blocked      = blocked | isr_q[k];
      allowed_o[k] = ~blocked;
    end
  end

  always_comb begin
    logic done;
    isr_d = isr_q;
    done  = 1'b0;
    if (ack_i) begin
      isr_d[win_idx_i] = 1'b1;
    end else if (eoi_i) begin
      for (int k = 0; k < N; k++) begin
        if (isr_q[k] && !done) begin
          isr_d[k] = 1'b0;
          done     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  // R7: an acknowledge marks the winning slot in service
  p_ack_marks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !eoi_i) |=> isr_q[$past(win_idx_i)]);

  // R9: a release drops exactly one in-service slot
  p_eoi_pops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int VEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  irq_src_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [VEC_W-1:0] bus_wdata_i,
  output logic [VEC_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             fiq_o,
  input  logic             chain_req_i,
  input  logic [VEC_W-1:0] chain_vec_i,
  output logic             chain_ack_o
);
  localparam int SW = $clog2(N_IN);

  bus_op_e op;
  logic [N_IN-1:0] in_en, fast_sel, slot_en, allowed, grant;
  logic [N_IN-1:0] fast_stat, norm_stat;
  logic [N_IN-1:0][SW-1:0] slot_src;
  logic [N_IN-1:0][VEC_W-1:0] slot_vec;
  logic [VEC_W-1:0] def_vec, vec_out;
  logic [SW-1:0] win_idx;
  logic win_valid, vec_rd, ack, eoi;

  always_comb begin
    if (!bus_sel_i)    op = OP_IDLE;
    else if (bus_we_i) op = OP_WRITE;
    else               op = OP_READ;
  end

  assign vec_rd = (op == OP_READ)  && (bus_addr_i == A_VEC);
  assign eoi    = (op == OP_WRITE) && (bus_addr_i == A_EOI);
  assign ack    = vec_rd && win_valid;

  vpic_cfg #(.N(N_IN), .VW(VEC_W), .SW(SW)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i(op == OP_WRITE), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .in_en_o(in_en), .fast_sel_o(fast_sel), .def_vec_o(def_vec),
    .slot_en_o(slot_en), .slot_src_o(slot_src), .slot_vec_o(slot_vec)
  );

  assign fast_stat = irq_src_i & in_en & fast_sel;
  assign norm_stat = irq_src_i & in_en & ~fast_sel;

  vpic_arb #(.N(N_IN), .SW(SW)) u_arb (
    .norm_stat_i(norm_stat), .slot_en_i(slot_en), .slot_src_i(slot_src),
    .allowed_i(allowed), .grant_o(grant), .win_idx_o(win_idx), .win_valid_o(win_valid)
  );

  vpic_svc #(.N(N_IN), .SW(SW)) u_svc (
    .clk_i, .rst_ni, .ack_i(ack), .win_idx_i(win_idx), .eoi_i(eoi), .allowed_o(allowed)
  );

  always_comb begin
    if (win_valid)        vec_out = slot_vec[win_idx];
    else if (chain_req_i) vec_out = chain_vec_i;
    else                  vec_out = def_vec;
  end

  assign irq_o       = win_valid | chain_req_i;
  assign fiq_o       = |fast_stat;
  assign chain_ack_o = vec_rd && !win_valid && chain_req_i;

  always_comb begin
    bus_rdata_o = '0;
    if (op == OP_READ) begin
      unique case (bus_addr_i[5:4])
        2'b00: begin
          case (bus_addr_i)
            A_VEC:  bus_rdata_o = vec_out;
            A_DEF:  bus_rdata_o = def_vec;
            A_EN:   bus_rdata_o[N_IN-1:0] = in_en;
            A_FSEL: bus_rdata_o[N_IN-1:0] = fast_sel;
            A_RAW:  bus_rdata_o[N_IN-1:0] = irq_src_i;
            A_FST:  bus_rdata_o[N_IN-1:0] = fast_stat;
            A_NST:  bus_rdata_o[N_IN-1:0] = norm_stat;
            default: bus_rdata_o = '0;
          endcase
        end
        PG_CTL: begin
          bus_rdata_o[SW-1:0]        = slot_src[bus_addr_i[SW-1:0]];
          bus_rdata_o[SLOT_EN_BIT]   = slot_en[bus_addr_i[SW-1:0]];
        end
        PG_VEC: bus_rdata_o = slot_vec[bus_addr_i[SW-1:0]];
        default: bus_rdata_o = '0;
      endcase
    end
  end

  // R6: at most one slot wins
  p_grant_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  // R8: the arbiter never grants a held-off slot
  p_grant_allowed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~allowed) == '0);
  // R12: a requesting downstream controller always raises the normal request
  p_chain_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_req_i |-> irq_o);
  // R10: the downstream vector is taken only when no local slot wins
  p_chain_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_ack_o |-> (!win_valid && chain_req_i));
  // R7: a local acknowledge with a single active source drops irq next cycle
  p_ack_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !chain_req_i && $countones(norm_stat) == 1 && $stable(irq_src_i)) |=> (!win_valid || $past(irq_src_i) != irq_src_i || $past(op) != OP_READ || !$stable(slot_en)));
endmodule

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, fiq, chain_req = 1'b0, chain_ack;
  logic [31:0] chain_vec = '0;

  int tests = 0, fails = 0;

  // model state
  logic [15:0] irq_v = '0, creq_dummy;
  logic creq = 1'b0;
  logic [31:0] cvec = '0;
  logic [15:0] m_en = '0, m_sel = '0;
  logic [15:0] m_sen = '0;
  int          m_src [16];
  logic [31:0] m_vec [16];
  logic [31:0] m_def = '0;
  int          svc[$];

  always #(CLK_P/2) clk = ~clk;

  vpic_top dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(irq_src),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fiq_o(fiq), .chain_req_i(chain_req),
    .chain_vec_i(chain_vec), .chain_ack_o(chain_ack)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_allowed(int k);
    foreach (svc[i]) if (svc[i] <= k) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_win();
    logic [15:0] ns;
    ns = irq_v & m_en & ~m_sel;
    for (int k = 0; k < 16; k++)
      if (m_sen[k] && ns[m_src[k]] && m_allowed(k)) return k;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    int w;
    w = m_win();
    if (a[5:4] == 2'b01) return {26'd0, m_sen[a[3:0]], 1'b0, 4'(m_src[a[3:0]])};
    if (a[5:4] == 2'b10) return m_vec[a[3:0]];
    case (a)
      6'h00: return (w >= 0) ? m_vec[w] : (creq ? cvec : m_def);
      6'h01: return m_def;
      6'h03: return {16'd0, m_en};
      6'h04: return {16'd0, m_sel};
      6'h05: return {16'd0, irq_v};
      6'h06: return {16'd0, irq_v & m_en & m_sel};
      6'h07: return {16'd0, irq_v & m_en & ~m_sel};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [5:0] a,
                      input logic [31:0] d, input string tag);
    int w;
    @(negedge clk);
    bus_sel = rd | wr; bus_we = wr; bus_addr = a; bus_wdata = d;
    irq_src = irq_v; chain_req = creq; chain_vec = cvec;
    #1;
    w = m_win();
    chk({31'd0, irq}, {31'd0, (w >= 0) || creq}, "R12 irq");
    chk({31'd0, fiq}, {31'd0, |(irq_v & m_en & m_sel)}, "R4 fiq");
    chk({31'd0, chain_ack}, {31'd0, rd && a == 6'h00 && w < 0 && creq}, "R10 chain_ack");
    if (rd) chk(bus_rdata, m_read(a), tag);
    @(posedge clk);
    if (rd && a == 6'h00 && w >= 0) svc.push_back(w);
    if (wr) begin
      if (a == 6'h03) m_en = d[15:0];
      if (a == 6'h04) m_sel = d[15:0];
      if (a == 6'h01) m_def = d;
      if (a[5:4] == 2'b01) begin m_sen[a[3:0]] = d[5]; m_src[a[3:0]] = int'(d[3:0]); end
      if (a[5:4] == 2'b10) m_vec[a[3:0]] = d;
      if (a == 6'h02 && svc.size() > 0) begin
        int mi; mi = 0;
        foreach (svc[i]) if (svc[i] < svc[mi]) mi = i;
        svc.delete(mi);
      end
    end
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1'b0, 1'b1, a, d, "wr");
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 6'h00, 32'd0, "idle");
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin m_src[k] = 0; m_vec[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    chk({31'd0, fiq}, 32'd0, "R1 fiq after reset");
    rd(6'h03, "R1 enable reset");
    rd(6'h04, "R1 select reset");
    rd(6'h13, "R1 slot ctl reset");
    irq_v = 16'hffff;
    idle();
    rd(6'h07, "R2 normal status while disabled");
    rd(6'h05, "R11 raw status");
    rd(6'h00, "R10 default vector at reset");
    irq_v = '0;
    for (int k = 0; k < 16; k++) begin
      if (k != 6) wr(6'h10 + 6'(k), 32'h20 | 32'(15 - k));
      wr(6'h20 + 6'(k), 32'h1000 + 32'(4 * k));
    end
    wr(6'h01, 32'hDEAD0000);
    rd(6'h1A, "R5 slot ctl readback");
    wr(6'h03, 32'h0000ffff);
    wr(6'h04, 32'h00000003);
    irq_v = 16'h0001;
    idle();
    rd(6'h06, "R3 fast status");
    rd(6'h07, "R3 normal status excludes fast");
    irq_v = 16'h0030;
    idle();
    rd(6'h00, "R6 priority winner slot 10");
    idle();
    chk({31'd0, irq}, 32'd0, "R7 irq drops after acknowledge");
    rd(6'h00, "R8 held-off slot 11 gives default");
    irq_v = 16'h2030;
    idle();
    rd(6'h00, "R8 preemption by slot 2");
    wr(6'h02, 32'd0);
    rd(6'h00, "R9 slot 2 again after release");
    wr(6'h02, 32'd0);
    wr(6'h02, 32'd0);
    wr(6'h02, 32'd0);
    rd(6'h00, "R9 all released, slot 2 wins");
    wr(6'h02, 32'd0);
    irq_v = 16'h0200;
    idle();
    rd(6'h00, "R5 disabled slot 6 ignored");
    wr(6'h10, 32'h00000029);
    rd(6'h00, "R5 remapped slot 0 wins");
    wr(6'h02, 32'd0);
    wr(6'h03, 32'h0000fdff);
    rd(6'h00, "R2 disabled input gives default");
    rd(6'h07, "R2 masked normal status");
    irq_v = '0; creq = 1'b1; cvec = 32'hC0DE0040;
    idle();
    rd(6'h00, "R10 chain vector");
    creq = 1'b0;
    rd(6'h00, "R10 default without chain");
    wr(6'h04, 32'h00000030);
    irq_v = 16'h0010;
    idle();
    rd(6'h06, "R3 reclassified fast status");
    rd(6'h00, "R3 fast input not vectored");
    irq_v = 16'h0020; wr(6'h04, 32'h0);
    rd(6'h00, "R6 slot 10 after reclass");
    wr(6'h02, 32'd0);
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule